// File: doc/BRIEF.md
# UART Transmit Buffer and Status Flags

This block sits between the register bank of a UART and its bit serializer. It accepts byte writes from the host and holds them until the serializer can take them. It also keeps the two transmit status flags that software polls: transmitter empty and transmit data request. Three places can hold a character. The shift register holds the character being serialized. A single holding register is used when the FIFO is off. A transmit FIFO with a parameterized depth is used when the FIFO is on.

A write to an idle transmitter skips all buffering and loads the shift register at once. When the transmitter is busy, the byte is placed in the FIFO or in the holding register, depending on the mode. When there is no room, the byte is lost. In FIFO mode the data-request flag follows a half-full rule instead of emptiness. The serializer reads the character through a valid/data pair. It reports the end of each character with a one-cycle done pulse. A flush request empties the buffers and sets both status flags.

When a done pulse and a write arrive in the same cycle, the done pulse is applied first. The write then sees the state left by that completion.

Top module: `uart_tx_buffer`

## Requirements
- R1: After reset, tx_empty_o = 1, tx_req_o = 1 and shift_valid_o = 0.
- R2: A write while tx_empty_o = 1 loads wr_data_i into the shift register. On the next cycle tx_empty_o = 0, shift_valid_o = 1 and shift_data_o equals the written byte, in either mode.
- R3: In FIFO mode (fifo_en_i = 1), a write while the transmitter is busy appends the byte to the FIFO. tx_req_o becomes 0 once the occupancy is greater than FIFO_DEPTH/2.
- R4: In FIFO mode, a write that finds FIFO_DEPTH entries already stored is discarded. The FIFO contents and order are unchanged, and the occupancy never exceeds FIFO_DEPTH.
- R5: In FIFO mode, a done pulse while the FIFO holds entries moves the oldest entry into the shift register. tx_req_o becomes 1 if the remaining occupancy is at most FIFO_DEPTH/2, and is otherwise left as it was.
- R6: In FIFO mode, a done pulse with an empty FIFO sets tx_empty_o to 1.
- R7: In non-FIFO mode, a write while busy with tx_req_o = 1 stores the byte in the holding register and clears tx_req_o.
- R8: In non-FIFO mode, a write while busy with tx_req_o = 0 is dropped. The holding register, shift register and flags are unchanged.
- R9: In non-FIFO mode, a done pulse with tx_req_o = 0 moves the holding byte to the shift register and sets tx_req_o. A done pulse with tx_req_o = 1 sets tx_empty_o.
- R10: flush_i empties the FIFO and sets tx_empty_o and tx_req_o to 1 on the next cycle. A write or done pulse in the same cycle has no effect.
- R11: A done pulse and a write in the same cycle apply the completion first. The write then sees the updated flags and occupancy.
- R12: shift_valid_o is the inverse of tx_empty_o. A done pulse while tx_empty_o = 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host write strobe to the transmit data register |
| wr_data_i | input | DATA_W | Byte written by the host |
| fifo_en_i | input | 1 | 1 selects FIFO mode, 0 selects single holding register |
| flush_i | input | 1 | Empty the transmit buffers and set both flags |
| char_done_i | input | 1 | Single-cycle pulse from the serializer at the end of a character |
| shift_data_o | output | DATA_W | Character currently offered to the serializer |
| shift_valid_o | output | 1 | shift_data_o holds a character to send |
| tx_empty_o | output | 1 | Transmitter empty: shift register and buffers idle |
| tx_req_o | output | 1 | Transmit data request |

## Verification
The bound checker checks properties on every cycle. It checks that a flush leaves both flags set and the FIFO empty. It checks that a write to an idle transmitter appears on the shift outputs one cycle later. It checks that occupancy stays within the depth, that filling past the half mark clears the request flag, and that a dropped non-FIFO write leaves the shift data and flags untouched. It also checks that the empty flag only rises after a completion or a flush. Some behaviours depend on whole sequences, and only the bench scenarios can show them. These are the first-in-first-out order of drained bytes, the loss of bytes written into a full FIFO, and the exact point at which the request flag returns during a drain. They also include the transfer from the holding register and the order of a simultaneous completion and write. The bench sweeps every fill level of a small FIFO in both modes.

// File: rtl/uart_txb_pkg.sv
package uart_txb_pkg;

  // outcome of a serializer completion
  typedef enum logic [1:0] {
    EV_NONE,
    EV_POP,
    EV_TAKE_HOLD,
    EV_IDLE
  } done_ev_e;

  function automatic int cnt_width(input int depth);
    return $clog2(depth + 1);
  endfunction

  function automatic int ptr_width(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/txb_fifo.sv
module txb_fifo
  import uart_txb_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int CNT_W = cnt_width(DEPTH),
  localparam int PTR_W = ptr_width(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  count_o
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0]  count_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else if (clr_i) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   count_q <= count_q + CNT_W'(1);
        2'b01:   count_q <= count_q - CNT_W'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !clr_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = count_q;

endmodule

// File: rtl/txb_ctrl.sv
module txb_ctrl
  import uart_txb_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int CNT_W = cnt_width(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              fifo_en_i,
  input  logic              flush_i,
  input  logic              char_done_i,
  input  logic [CNT_W-1:0]  fifo_count_i,
  input  logic [DATA_W-1:0] fifo_head_i,
  output logic              fifo_push_o,
  output logic              fifo_pop_o,
  output logic              fifo_clr_o,
  output logic [DATA_W-1:0] shift_data_o,
  output logic              temt_o,
  output logic              tdrq_o
);

  localparam logic [CNT_W-1:0] HALF = CNT_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] shift_q, shift_d, hold_q, hold_d;
  logic              temt_q, temt_d, tdrq_q, tdrq_d;
  logic              temt_mid, tdrq_mid;
  logic [CNT_W-1:0]  cnt_mid;
  logic              push, pop;
  done_ev_e          ev;

  // completion outcome
  always_comb begin
    ev = EV_NONE;
    if (char_done_i && !temt_q) begin
      if (fifo_en_i) ev = (fifo_count_i != '0) ? EV_POP : EV_IDLE;
      else           ev = tdrq_q ? EV_IDLE : EV_TAKE_HOLD;
    end
  end

  // completion first, then the write sees its result
  always_comb begin
    shift_d  = shift_q;
    hold_d   = hold_q;
    temt_mid = temt_q;
    tdrq_mid = tdrq_q;
    pop      = 1'b0;
    push     = 1'b0;
    case (ev)
      EV_POP: begin
        pop     = 1'b1;
        shift_d = fifo_head_i;
        if ((fifo_count_i - CNT_W'(1)) <= HALF) tdrq_mid = 1'b1;
      end
      EV_TAKE_HOLD: begin
        shift_d  = hold_q;
        tdrq_mid = 1'b1;
      end
      EV_IDLE: temt_mid = 1'b1;
      default: ;
    endcase
    cnt_mid = fifo_count_i - CNT_W'(pop);

    temt_d = temt_mid;
    tdrq_d = tdrq_mid;
    if (wr_en_i) begin
      if (temt_mid) begin
        shift_d = wr_data_i;
        temt_d  = 1'b0;
      end else if (fifo_en_i) begin
        push = (cnt_mid < FULL);
        if ((cnt_mid + CNT_W'(push)) > HALF) tdrq_d = 1'b0;
      end else if (tdrq_mid) begin
        hold_d = wr_data_i;
        tdrq_d = 1'b0;
      end
    end

    if (flush_i) begin
      shift_d = shift_q;
      hold_d  = hold_q;
      temt_d  = 1'b1;
      tdrq_d  = 1'b1;
      push    = 1'b0;
      pop     = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      hold_q  <= '0;
      temt_q  <= 1'b1;
      tdrq_q  <= 1'b1;
    end else begin
      shift_q <= shift_d;
      hold_q  <= hold_d;
      temt_q  <= temt_d;
      tdrq_q  <= tdrq_d;
    end
  end

  assign fifo_push_o  = push;
  assign fifo_pop_o   = pop;
  assign fifo_clr_o   = flush_i;
  assign shift_data_o = shift_q;
  assign temt_o       = temt_q;
  assign tdrq_o       = tdrq_q;

endmodule

// File: rtl/uart_tx_buffer.sv
module uart_tx_buffer
  import uart_txb_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int DATA_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              fifo_en_i,
  input  logic              flush_i,
  input  logic              char_done_i,
  output logic [DATA_W-1:0] shift_data_o,
  output logic              shift_valid_o,
  output logic              tx_empty_o,
  output logic              tx_req_o
);

  localparam int CNT_W = cnt_width(FIFO_DEPTH);

  logic              fifo_push, fifo_pop, fifo_clr;
  logic [DATA_W-1:0] fifo_head;
  logic [CNT_W-1:0]  fifo_count;
  logic              temt;

  txb_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) i_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (fifo_clr),
    .push_i  (fifo_push),
    .pop_i   (fifo_pop),
    .wdata_i (wr_data_i),
    .rdata_o (fifo_head),
    .count_o (fifo_count)
  );

  txb_ctrl #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .fifo_en_i    (fifo_en_i),
    .flush_i      (flush_i),
    .char_done_i  (char_done_i),
    .fifo_count_i (fifo_count),
    .fifo_head_i  (fifo_head),
    .fifo_push_o  (fifo_push),
    .fifo_pop_o   (fifo_pop),
    .fifo_clr_o   (fifo_clr),
    .shift_data_o (shift_data_o),
    .temt_o       (temt),
    .tdrq_o       (tx_req_o)
  );

  assign tx_empty_o    = temt;
  assign shift_valid_o = !temt;

endmodule

// File: rtl/uart_txb_chk.sv
module uart_txb_chk
  import uart_txb_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int DATA_W     = 8,
  localparam int CNT_W     = cnt_width(FIFO_DEPTH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              fifo_en_i,
  input logic              flush_i,
  input logic              char_done_i,
  input logic [DATA_W-1:0] shift_data_o,
  input logic              shift_valid_o,
  input logic              tx_empty_o,
  input logic              tx_req_o,
  input logic [CNT_W-1:0]  fifo_count_i
);

  localparam logic [CNT_W-1:0] HALF = CNT_W'(FIFO_DEPTH / 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FIFO_DEPTH);

  // R10
  flush_sets_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> tx_empty_o && tx_req_o && fifo_count_i == '0);

  // R2
  idle_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && tx_empty_o && !flush_i |=> shift_valid_o && shift_data_o == $past(wr_data_i));

  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_count_i <= FULL);

  // R3
  half_full_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_en_i && wr_en_i && !tx_empty_o && !flush_i && !char_done_i && fifo_count_i >= HALF
    |=> !tx_req_o);

  // R8
  drop_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i && wr_en_i && !tx_empty_o && !tx_req_o && !char_done_i && !flush_i
    |=> !tx_req_o && !tx_empty_o && $stable(shift_data_o));

  // R12
  empty_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_empty_o) |-> $past(flush_i) || $past(char_done_i));

endmodule

bind uart_tx_buffer uart_txb_chk #(.FIFO_DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_data_i     (wr_data_i),
  .fifo_en_i     (fifo_en_i),
  .flush_i       (flush_i),
  .char_done_i   (char_done_i),
  .shift_data_o  (shift_data_o),
  .shift_valid_o (shift_valid_o),
  .tx_empty_o    (tx_empty_o),
  .tx_req_o      (tx_req_o),
  .fifo_count_i  (fifo_count)
);

// File: tb/test_uart_tx_buffer.sv
module test_uart_tx_buffer;
  localparam int DEPTH = 8;
  localparam int HALF  = DEPTH / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, fifo_en = 1'b0, flush = 1'b0, done = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] shift_data;
  logic       shift_valid, tx_empty, tx_req;

  int n_run = 0, n_fail = 0;

  // reference state
  logic       m_temt = 1'b1, m_tdrq = 1'b1;
  logic [7:0] m_shift = '0, m_hold = '0;
  logic [7:0] m_q [$];

  always #10 clk = ~clk;

  uart_tx_buffer #(.FIFO_DEPTH(DEPTH), .DATA_W(8)) i_uart_tx_buffer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .fifo_en_i(fifo_en), .flush_i(flush), .char_done_i(done),
    .shift_data_o(shift_data), .shift_valid_o(shift_valid),
    .tx_empty_o(tx_empty), .tx_req_o(tx_req)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    chk(req, "tx_empty", tx_empty, m_temt);
    chk(req, "tx_req", tx_req, m_tdrq);
    chk(req, "shift_valid", shift_valid, !m_temt);
    if (!m_temt) chk(req, "shift_data", shift_data, m_shift);
  endtask

  // one cycle: apply stimulus, advance reference, compare after the edge
  task automatic op(input logic w, input logic [7:0] d, input logic dn, input logic fl);
    string tag = "R12";
    logic  done_hit = 1'b0;
    wr_en = w; wr_data = d; done = dn; flush = fl;
    @(posedge clk);
    #2;
    wr_en = 1'b0; done = 1'b0; flush = 1'b0;
    if (fl) begin
      m_q.delete(); m_temt = 1'b1; m_tdrq = 1'b1; tag = "R10";
    end else begin
      if (dn && !m_temt) begin
        done_hit = 1'b1;
        if (fifo_en) begin
          if (m_q.size() > 0) begin
            m_shift = m_q.pop_front();
            if (m_q.size() <= HALF) m_tdrq = 1'b1;
            tag = "R5";
          end else begin
            m_temt = 1'b1; tag = "R6";
          end
        end else begin
          if (m_tdrq) m_temt = 1'b1;
          else begin m_shift = m_hold; m_tdrq = 1'b1; end
          tag = "R9";
        end
      end
      if (w) begin
        if (m_temt) begin
          m_shift = d; m_temt = 1'b0; tag = "R2";
        end else if (fifo_en) begin
          if (m_q.size() < DEPTH) begin m_q.push_back(d); tag = "R3"; end
          else tag = "R4";
          if (m_q.size() > HALF) m_tdrq = 1'b0;
        end else if (m_tdrq) begin
          m_hold = d; m_tdrq = 1'b0; tag = "R7";
        end else tag = "R8";
        if (done_hit) tag = "R11";
      end
    end
    compare(tag);
  endtask

  // drain until idle, checking every pop (R5, R6)
  task automatic drain();
    for (int k = 0; k < DEPTH + 4 && !m_temt; k++) op(1'b0, 8'h00, 1'b1, 1'b0);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #35 rst_n = 1'b1;
    @(posedge clk); #2;
    compare("R1");

    // done while idle has no effect
    op(1'b0, 8'h00, 1'b1, 1'b0);

    // FIFO mode: every fill level from empty to beyond full
    fifo_en = 1'b1;
    for (int n = 0; n <= DEPTH + 2; n++) begin
      op(1'b0, 8'h00, 1'b0, 1'b1);
      op(1'b1, 8'(8'h10 * n), 1'b0, 1'b0);
      for (int j = 0; j < n; j++) op(1'b1, 8'(n * 16 + j + 1), 1'b0, 1'b0);
      drain();
    end

    // FIFO mode: completion and write together at several levels
    for (int n = 0; n <= DEPTH; n++) begin
      op(1'b1, 8'hA0, 1'b0, 1'b0);
      for (int j = 0; j < n; j++) op(1'b1, 8'(8'hB0 + j), 1'b0, 1'b0);
      op(1'b1, 8'hCC, 1'b1, 1'b0);
      op(1'b1, 8'hCD, 1'b1, 1'b0);
      drain();
    end

    // FIFO mode: flush with work pending, write ignored in that cycle
    op(1'b1, 8'h55, 1'b0, 1'b0);
    for (int j = 0; j < DEPTH; j++) op(1'b1, 8'(j), 1'b0, 1'b0);
    op(1'b1, 8'h66, 1'b1, 1'b1);
    op(1'b0, 8'h00, 1'b1, 1'b0);

    // non-FIFO mode
    fifo_en = 1'b0;
    op(1'b1, 8'h31, 1'b0, 1'b0);
    op(1'b1, 8'h32, 1'b0, 1'b0);
    op(1'b1, 8'h33, 1'b0, 1'b0);
    op(1'b0, 8'h00, 1'b1, 1'b0);
    op(1'b0, 8'h00, 1'b1, 1'b0);
    op(1'b0, 8'h00, 1'b1, 1'b0);
    for (int p = 0; p < 4; p++) begin
      op(1'b1, 8'(8'h40 + p), 1'b0, 1'b0);
      if (p > 0) op(1'b1, 8'(8'h50 + p), 1'b0, 1'b0);
      op(1'b1, 8'(8'h60 + p), 1'b1, 1'b0);
      op(1'b1, 8'(8'h70 + p), p[0], 1'b0);
      drain();
    end
    op(1'b1, 8'h77, 1'b0, 1'b0);
    op(1'b1, 8'h78, 1'b0, 1'b0);
    op(1'b0, 8'h00, 1'b0, 1'b1);
    op(1'b1, 8'h79, 1'b0, 1'b0);
    drain();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule